// File: doc/BRIEF.md
# Three-Mode Eight-Pin I/O Port Controller

This block sits between a host register bus, a programmable logic array and eight bidirectional pads. Each pad is driven in one of three ways. In host I/O mode the host writes a data-out register that drives the pin and reads the live pad level back. In logic-array mode the pin carries a signal from the logic array, and an output-enable product term gates it. In address-out mode the pin drives a bit of the low address byte to external devices. That byte is either the value captured from a multiplexed address/data bus at the end of an address strobe, or the address bus taken directly when the bus is not multiplexed.

Two bits choose the mode of each pin: a Control bit and a Direction bit. Control 0 gives host I/O. Control 1 with Direction 0 gives logic-array mode. Control 1 with Direction 1 gives address-out. The pad output enable is the Direction bit ORed with that pin's external product-term enable. A build option removes the Control register entirely. In that build, a fixed per-pin mask places pins in logic-array mode and every other pin stays in host I/O mode.

A two-state machine captures the multiplexed address. In state `LAT_IDLE` it waits with the strobe low. The transition `IDLE->STROBE` fires when the strobe is seen high and samples the bus. `LAT_STROBE` keeps sampling while the strobe stays high. The transition `STROBE->IDLE` fires when the strobe falls, and it commits the last sampled byte to the held address.

Top module: `iox_port`

## Requirements
- R1: After reset the Data Out, Direction and Control registers are all 0. Every pin is then a host I/O input: pad_oe is 0 while pt_oe is 0, and pad_out is 0.
- R2: Register offsets are as follows. Writing offset 0 loads Data Out, offset 1 loads Direction and offset 2 loads Control. Reads of offset 1 and 2 return the stored value. Offset 3 reads 0, and writes to it change nothing.
- R3: A read of offset 0 returns the current pad_in levels.
- R4: For every pin, pad_oe equals the Direction bit OR the pin's pt_oe input.
- R5: A pin whose Control bit is 0 (host I/O mode) drives its Data Out bit on pad_out.
- R6: A pin with Control 1 and Direction 0 (logic-array mode) drives its pld_out bit on pad_out.
- R7: A pin with Control 1 and Direction 1 (address-out mode) drives the held strobe-captured address bit on pad_out while bus_muxed is 1.
- R8: In address-out mode with bus_muxed 0, pad_out carries bus_addr directly, with no latching.
- R9: The held address takes the bus_addr value sampled in the last clock cycle with addr_strobe high. It updates on the first edge that sees the strobe low, and it is unchanged until the next strobe pulse ends.
- R10: With HAS_CTRL = 0, pins set in PLD_PINS behave in logic-array mode and all others in host I/O mode, whatever the Direction bits. Offset 2 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe for this port |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| bus_muxed | input | 1 | 1 = multiplexed address/data bus |
| bus_addr | input | 8 | Low address byte, or the AD bus when multiplexed |
| addr_strobe | input | 1 | Address-latch strobe, active high |
| pld_out | input | 8 | Logic-array output per pin |
| pt_oe | input | 8 | Product-term output enable per pin |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The bench sweeps all 256 Direction values against shifting product-term enables. A design that used only one of the two terms would drop or float pins. It also walks several mixed Control/Direction patterns so that all three modes appear on neighbouring pins at once. A swapped mode decode would show up as pld_out leaking into host pins or address bits leaking into logic-array pins. Strobes are replayed with the bus changing both during the high phase and after the fall. An early or transparent latch would then present the wrong byte or lose the held value. The no-Control build is checked with every Direction bit set, because a decode that still honoured Direction would put its logic-array pins into address-out mode.

// File: rtl/iox_pkg.sv
package iox_pkg;

    typedef enum logic [1:0] {
        PIN_HOST = 2'd0,
        PIN_PLD  = 2'd1,
        PIN_ADDR = 2'd2
    } pin_mode_t;

    typedef enum logic {
        LAT_IDLE   = 1'b0,
        LAT_STROBE = 1'b1
    } lat_state_t;

    localparam int unsigned OFS_W = 2;
    localparam logic [OFS_W-1:0] OFS_DATA = 2'd0;
    localparam logic [OFS_W-1:0] OFS_DIR  = 2'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 2'd2;

    function automatic pin_mode_t decode_mode(input logic ctl, input logic dir);
        if (!ctl)
            return PIN_HOST;
        else if (dir)
            return PIN_ADDR;
        else
            return PIN_PLD;
    endfunction

endpackage

// File: rtl/iox_regs.sv
module iox_regs
    import iox_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter bit          HAS_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [OFS_W-1:0] ofs,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] dout_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] ctrl_q
);

    logic wr_dout, wr_dir, wr_ctrl;

    always_comb begin
        wr_dout = sel && wr && (ofs == OFS_DATA);
        wr_dir  = sel && wr && (ofs == OFS_DIR);
        wr_ctrl = sel && wr && (ofs == OFS_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_dout) dout_q <= wdata;
            if (wr_dir)  dir_q  <= wdata;
        end
    end

    generate
        if (HAS_CTRL) begin : g_ctrl
            logic [WIDTH-1:0] ctrl_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ctrl_r <= '0;
                else if (wr_ctrl)
                    ctrl_r <= wdata;
            end
            assign ctrl_q = ctrl_r;
        end else begin : g_no_ctrl
            assign ctrl_q = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_DATA: rdata = pad_in;
            OFS_DIR:  rdata = dir_q;
            OFS_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
        endcase
    end

    // R2: a Direction write lands one edge later
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wdata)));

    // R2: without a Direction write the register holds
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    // R2: Data Out changes only on its own offset
    p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dout |=> $stable(dout_q));

endmodule

// File: rtl/iox_addr_latch.sv
module iox_addr_latch
    import iox_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] bus,
    output logic [WIDTH-1:0] held
);

    lat_state_t       state_q, state_d;
    logic [WIDTH-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LAT_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE:   if (strobe)  state_d = LAT_STROBE;
            LAT_STROBE: if (!strobe) state_d = LAT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            held  <= '0;
        end else begin
            unique case (state_q)
                LAT_IDLE: begin
                    if (strobe) cap_q <= bus;
                end
                LAT_STROBE: begin
                    if (strobe) cap_q <= bus;
                    else        held  <= cap_q;
                end
            endcase
        end
    end

    // R9: held address only moves on the strobe's falling edge
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == LAT_STROBE && !strobe) |=> $stable(held));

    // R9: the committed byte is the bus seen on the last high cycle
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LAT_STROBE && !strobe) |=> (held == $past(bus, 2)));

endmodule

// File: rtl/iox_pin_cell.sv
module iox_pin_cell
    import iox_pkg::*;
#(
    parameter bit HAS_CTRL = 1'b1,
    parameter bit IS_PLD   = 1'b0
) (
    input  logic ctl,
    input  logic dir,
    input  logic dout,
    input  logic pld,
    input  logic addr_bit,
    input  logic pt_oe,
    output logic pad_out,
    output logic pad_oe
);

    pin_mode_t mode;

    always_comb begin
        if (HAS_CTRL)
            mode = decode_mode(ctl, dir);
        else
            mode = IS_PLD ? PIN_PLD : PIN_HOST;
    end

    always_comb begin
        pad_out = 1'b0;
        unique case (mode)
            PIN_HOST: pad_out = dout;
            PIN_PLD:  pad_out = pld;
            PIN_ADDR: pad_out = addr_bit;
        endcase
        pad_oe = dir | pt_oe;
    end

endmodule

// File: rtl/iox_port.sv
module iox_port
    import iox_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter bit          HAS_CTRL = 1'b1,
    parameter logic [7:0]  PLD_PINS = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic [1:0]       host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             bus_muxed,
    input  logic [WIDTH-1:0] bus_addr,
    input  logic             addr_strobe,
    input  logic [WIDTH-1:0] pld_out,
    input  logic [WIDTH-1:0] pt_oe,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    localparam int unsigned MASK_W = (WIDTH < 8) ? WIDTH : 8;

    logic [WIDTH-1:0] dout_q, dir_q, ctrl_q;
    logic [WIDTH-1:0] held_addr, addr_src;

    iox_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (host_sel),
        .wr     (host_wr),
        .ofs    (host_addr),
        .wdata  (host_wdata),
        .pad_in (pad_in),
        .rdata  (host_rdata),
        .dout_q (dout_q),
        .dir_q  (dir_q),
        .ctrl_q (ctrl_q)
    );

    iox_addr_latch #(.WIDTH(WIDTH)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (addr_strobe),
        .bus    (bus_addr),
        .held   (held_addr)
    );

    assign addr_src = bus_muxed ? held_addr : bus_addr;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            localparam bit PIN_IS_PLD = (i < MASK_W) ? PLD_PINS[i] : 1'b0;
            iox_pin_cell #(.HAS_CTRL(HAS_CTRL), .IS_PLD(PIN_IS_PLD)) u_cell (
                .ctl      (ctrl_q[i]),
                .dir      (dir_q[i]),
                .dout     (dout_q[i]),
                .pld      (pld_out[i]),
                .addr_bit (addr_src[i]),
                .pt_oe    (pt_oe[i]),
                .pad_out  (pad_out[i]),
                .pad_oe   (pad_oe[i])
            );
        end
    endgenerate

    // R4: no pin drives unless Direction or its product term asks for it
    p_input_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~pt_oe & pad_oe) == '0));

    // R4: a set Direction bit always enables the pad
    p_dir_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~pad_oe) == '0));

    generate
        if (HAS_CTRL) begin : g_chk
            // R5: host I/O pins follow Data Out
            p_host_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ((~ctrl_q & (pad_out ^ dout_q)) == '0));
            // R6: logic-array pins follow pld_out
            p_pld_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ((ctrl_q & ~dir_q & (pad_out ^ pld_out)) == '0));
            // R7: address pins on a multiplexed bus follow the held byte
            p_addr_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
                bus_muxed |-> ((ctrl_q & dir_q & (pad_out ^ held_addr)) == '0));
        end
    endgenerate

endmodule

// File: tb/test_iox_port.sv
module test_iox_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] NOCTL_PLD = 8'hF0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] rdata_a, rdata_b;
    logic       bus_muxed = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       addr_strobe = 1'b0;
    logic [7:0] pld_out = '0, pt_oe = '0, pad_in = '0;
    logic [7:0] out_a, oe_a, out_b, oe_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iox_port i_iox_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_a),
        .bus_muxed(bus_muxed), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
        .pld_out(pld_out), .pt_oe(pt_oe), .pad_in(pad_in),
        .pad_out(out_a), .pad_oe(oe_a)
    );

    iox_port #(.HAS_CTRL(1'b0), .PLD_PINS(NOCTL_PLD)) i_iox_port_noctl (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_b),
        .bus_muxed(bus_muxed), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
        .pld_out(pld_out), .pt_oe(pt_oe), .pad_in(pad_in),
        .pad_out(out_b), .pad_oe(oe_b)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] da, output logic [7:0] db);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1;
        da = rdata_a; db = rdata_b;
        host_sel = 1'b0;
    endtask

    // one strobe pulse: high for hi_cycles with the given bus bytes, then low
    task automatic strobe(input logic [7:0] v_first, input logic [7:0] v_last, input int hi_cycles);
        @(negedge clk);
        addr_strobe = 1'b1; bus_addr = v_first;
        for (int k = 1; k < hi_cycles; k++) begin
            @(negedge clk);
            bus_addr = v_last;
        end
        @(negedge clk);
        addr_strobe = 1'b0; bus_addr = ~v_last;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ra, rb;
        logic [7:0] lat_now;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 pad_oe", oe_a, 8'h00);
        chk("R1 pad_out", out_a, 8'h00);
        rd_reg(2'd1, ra, rb); chk("R1 dir", ra, 8'h00);
        rd_reg(2'd2, ra, rb); chk("R1 ctrl", ra, 8'h00);

        // R2 register map
        wr_reg(2'd1, 8'h5C); wr_reg(2'd2, 8'hA3); wr_reg(2'd0, 8'h71);
        rd_reg(2'd1, ra, rb); chk("R2 dir readback", ra, 8'h5C);
        rd_reg(2'd2, ra, rb); chk("R2 ctrl readback", ra, 8'hA3);
        rd_reg(2'd3, ra, rb); chk("R2 offset3 read", ra, 8'h00);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd1, ra, rb); chk("R2 dir after ofs3 write", ra, 8'h5C);
        rd_reg(2'd2, ra, rb); chk("R2 ctrl after ofs3 write", ra, 8'hA3);
        wr_reg(2'd2, 8'h00);
        chk("R2 dout after ofs3 write", out_a, 8'h71);

        // R3 data-in read sweep
        for (int v = 0; v < 256; v++) begin
            pad_in = 8'(v);
            rd_reg(2'd0, ra, rb);
            chk("R3 data in", ra, 8'(v));
        end

        // R4 output-enable sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] pt;
            pt = {8'(v) >> 4 | 8'(v) << 4} ^ 8'h5A;
            pt_oe = pt;
            wr_reg(2'd1, 8'(v));
            chk("R4 pad_oe", oe_a, 8'(v) | pt);
        end
        pt_oe = 8'h00;

        // capture a known byte for address-out checks (R9)
        wr_reg(2'd2, 8'hFF); wr_reg(2'd1, 8'hFF);
        bus_muxed = 1'b1;
        strobe(8'hC3, 8'hC3, 1);
        @(negedge clk); #1;
        chk("R9 capture single", out_a, 8'hC3);
        lat_now = 8'hC3;

        // R5-R8 mixed-mode patterns
        for (int p = 0; p < 6; p++) begin
            logic [7:0] c, d, dout, pld, exp, m_host, m_pld, m_addr;
            c    = 8'h0F << p | 8'h81 >> p;
            d    = 8'h33 ^ (8'h15 << p);
            dout = 8'h96 ^ 8'(p * 37);
            pld  = 8'h3C ^ 8'(p * 91);
            pld_out = pld;
            bus_addr = 8'h5A ^ 8'(p);
            wr_reg(2'd0, dout); wr_reg(2'd2, c); wr_reg(2'd1, d);
            m_host = ~c; m_pld = c & ~d; m_addr = c & d;
            for (int mx = 0; mx < 2; mx++) begin
                bus_muxed = mx[0];
                #1;
                exp = mx[0] ? lat_now : bus_addr;
                chk("R5 host pins", out_a & m_host, dout & m_host);
                chk("R6 logic-array pins", out_a & m_pld, pld & m_pld);
                if (mx[0]) chk("R7 latched address pins", out_a & m_addr, exp & m_addr);
                else       chk("R8 direct address pins", out_a & m_addr, exp & m_addr);
            end
        end

        // R9 strobe timing
        wr_reg(2'd2, 8'hFF); wr_reg(2'd1, 8'hFF);
        bus_muxed = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b1; bus_addr = 8'h27;
        @(negedge clk); #1;
        chk("R9 no update while strobe high", out_a, lat_now);
        bus_addr = 8'h6E;
        @(negedge clk); #1;
        chk("R9 still held while strobe high", out_a, lat_now);
        addr_strobe = 1'b0; bus_addr = 8'h11;
        @(negedge clk); #1;
        chk("R9 last high byte committed", out_a, 8'h6E);
        lat_now = 8'h6E;
        bus_addr = 8'hE4;
        @(negedge clk); @(negedge clk); #1;
        chk("R9 hold while strobe low", out_a, lat_now);
        strobe(8'h09, 8'hB2, 3);
        @(negedge clk); #1;
        chk("R9 multi-cycle strobe", out_a, 8'hB2);

        // R10 variant without Control register
        pld_out = 8'hA5;
        wr_reg(2'd0, 8'h3C); wr_reg(2'd1, 8'hFF); wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, ra, rb); chk("R10 ctrl reads zero", rb, 8'h00);
        chk("R10 mask pins from array", out_b & NOCTL_PLD, 8'hA5 & NOCTL_PLD);
        chk("R10 other pins host", out_b & ~NOCTL_PLD, 8'h3C & ~NOCTL_PLD);
        wr_reg(2'd1, 8'h00);
        chk("R10 dir-independent", out_b, (8'hA5 & NOCTL_PLD) | (8'h3C & ~NOCTL_PLD));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule